// File: doc/BRIEF.md
# Set/Clear Masked Interrupt Controller

This block gathers fourteen peripheral interrupt sources into two CPU request lines. It holds one pending flag per source and one enable (mask) bit per source. Sources 0 to 5 are the legacy group and drive request line 0. Sources 6 to 13 are the extended group and drive request line 1. A source reaches its line only while its pending flag and its mask bit are both set. A masked source still latches its flag, so enabling its mask later raises the line at once.

Software never writes the mask directly. Each mask write carries a pair of command bits per source, one to set that mask bit and one to clear it. The mask can be reached through a narrow legacy view that covers sources 0 to 5 or a wide extended view that covers all fourteen. Both views act on the same storage. Two live status inputs, card removed and button held, can be read beside the flags, and their rising edges raise flags 13 and 12. Access is through a simple bus with one cycle per transfer.

Top module: `irq_mask_ctrl`

## Requirements
- R1: After reset, all mask bits and all pending flags are 0, and both `irq_legacy` and `irq_ext` are low.
- R2: A one-cycle `src_event[n]` pulse (n = 0..11) sets pending flag n, and `src_ack[n]` clears it. When an event and an acknowledge for the same source arrive in the same cycle, the flag ends set.
- R3: A flag is latched whether or not its mask bit is set.
- R4: A write to address 2 (extended mask) changes mask bit n for n = 0..13 as follows: data bit 2n+1 sets it and data bit 2n clears it. If both bits of a pair are 1, or both are 0, the mask bit is unchanged. Reading address 2 returns mask bits 13..0 in data bits 13..0.
- R5: A write to address 1 (legacy mask) uses data bits 11..0 with the same pair layout, for sources 0..5 only. Data bits above 11 have no effect. Reading address 1 returns mask bits 5..0, with zeros above.
- R6: Mask bits 0..5 are one storage shared by both views. A change made through either view is seen on the next read of the other.
- R7: `irq_legacy` is the OR of pending-and-masked sources 0..5, and `irq_ext` is the OR of pending-and-masked sources 6..13. Both are registered and follow the clock edge that changes a flag or a mask bit.
- R8: Setting a mask bit while its flag is already pending raises the matching request line right after that write's clock edge, with no new event needed.
- R9: Reading address 0 returns the flags in bits 13..0, the live card-removed input in bit 15 (1 = removed) and the live button-held input in bit 14 (1 = held).
- R10: Flag 13 is set when `card_removed` goes from 0 to 1, and flag 12 is set when `button_held` goes from 0 to 1. A write to address 0 with data bit 13 or bit 12 set clears that flag. Other data bits of that write have no effect.
- R11: `rdata` is registered. It shows, just after the clock edge at which `addr` was presented, the state before that edge. Address 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the current address |
| addr | input | 2 | Register select: 0 flags/status, 1 legacy mask, 2 extended mask |
| wdata | input | 32 | Write data or command bits |
| rdata | output | 32 | Registered read data |
| src_event | input | 12 | One-cycle event pulses for sources 0..11 |
| src_ack | input | 12 | Acknowledge (flag clear) for sources 0..11 |
| card_removed | input | 1 | Live card status, 1 = removed |
| button_held | input | 1 | Live button status, 1 = held |
| irq_legacy | output | 1 | CPU request line 0 (sources 0..5) |
| irq_ext | output | 1 | CPU request line 1 (sources 6..13) |

## Verification
Flags, mask bits and both request lines update at the clock edge that samples the event, acknowledge, status change or write. The request lines therefore show the effect of a stimulus just after that one edge. The bench drives each stimulus at the falling edge and samples one time unit after the next rising edge. A register read gives the state that held before the edge at which its address was sampled, so every read is issued in a cycle after the write or event it checks.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int IRQC_SRC   = 14;
  localparam int IRQC_LEG   = 6;
  localparam int IRQC_DATA  = 32;

  typedef enum logic [1:0] {
    RA_FLAGS = 2'd0,
    RA_LMASK = 2'd1,
    RA_XMASK = 2'd2,
    RA_SPARE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/irqc_mask_bank.sv
module irqc_mask_bank #(
  parameter int NUM_SRC = 14,
  parameter int NUM_LEG = 6,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_leg,
  input  logic               wr_ext,
  input  logic [DATA_W-1:0]  cmd,
  output logic [NUM_SRC-1:0] mask_q,
  output logic [NUM_SRC-1:0] mask_nxt
);
  for (genvar n = 0; n < NUM_SRC; n++) begin : g_bit
    localparam bit IN_LEG = (n < NUM_LEG);
    logic en, do_set, do_clr;
    assign en     = wr_ext | (wr_leg & IN_LEG);
    assign do_set = en & cmd[2*n+1];
    assign do_clr = en & cmd[2*n];
    always_comb begin
      if (do_set && !do_clr)      mask_nxt[n] = 1'b1;
      else if (do_clr && !do_set) mask_nxt[n] = 1'b0;
      else                        mask_nxt[n] = mask_q[n];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else     mask_q <= mask_nxt;
  end
endmodule

// File: rtl/irqc_flag_bank.sv
module irqc_flag_bank #(
  parameter int NUM_SRC = 14
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] set_vec,
  input  logic [NUM_SRC-1:0] clr_vec,
  output logic [NUM_SRC-1:0] flag_q,
  output logic [NUM_SRC-1:0] flag_nxt
);
  assign flag_nxt = (flag_q & ~clr_vec) | set_vec;

  always_ff @(posedge clk) begin
    if (rst) flag_q <= '0;
    else     flag_q <= flag_nxt;
  end
endmodule

// File: rtl/irqc_req_gate.sv
module irqc_req_gate #(
  parameter int NUM_SRC = 14,
  parameter int NUM_LEG = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] flag_nxt,
  input  logic [NUM_SRC-1:0] mask_nxt,
  output logic               req_leg,
  output logic               req_ext
);
  logic [NUM_SRC-1:0] live;
  assign live = flag_nxt & mask_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_leg <= 1'b0;
      req_ext <= 1'b0;
    end else begin
      req_leg <= |live[NUM_LEG-1:0];
      req_ext <= |live[NUM_SRC-1:NUM_LEG];
    end
  end
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = IRQC_SRC,
  parameter int NUM_LEG = IRQC_LEG,
  parameter int DATA_W  = IRQC_DATA
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [1:0]           addr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata,
  input  logic [NUM_SRC-3:0]   src_event,
  input  logic [NUM_SRC-3:0]   src_ack,
  input  logic                 card_removed,
  input  logic                 button_held,
  output logic                 irq_legacy,
  output logic                 irq_ext
);
  localparam int NUM_EVT  = NUM_SRC - 2;
  localparam int BTN_IDX  = NUM_SRC - 2;
  localparam int CARD_IDX = NUM_SRC - 1;

  reg_addr_e ra;
  assign ra = reg_addr_e'(addr);

  logic wr_flags, wr_leg, wr_ext;
  assign wr_flags = wr_en && (ra == RA_FLAGS);
  assign wr_leg   = wr_en && (ra == RA_LMASK);
  assign wr_ext   = wr_en && (ra == RA_XMASK);

  // status edge capture
  logic card_prev, btn_prev;
  always_ff @(posedge clk) begin
    if (rst) begin
      card_prev <= 1'b0;
      btn_prev  <= 1'b0;
    end else begin
      card_prev <= card_removed;
      btn_prev  <= button_held;
    end
  end

  logic [NUM_SRC-1:0] set_vec, clr_vec;
  assign set_vec = {card_removed & ~card_prev, button_held & ~btn_prev, src_event};
  assign clr_vec = {wr_flags & wdata[CARD_IDX], wr_flags & wdata[BTN_IDX], src_ack};

  logic [NUM_SRC-1:0] pend_q, pend_nxt, mask_q, mask_nxt;

  irqc_flag_bank #(.NUM_SRC(NUM_SRC)) u_flags (
    .clk(clk), .rst(rst), .set_vec(set_vec), .clr_vec(clr_vec),
    .flag_q(pend_q), .flag_nxt(pend_nxt)
  );

  irqc_mask_bank #(.NUM_SRC(NUM_SRC), .NUM_LEG(NUM_LEG), .DATA_W(DATA_W)) u_mask (
    .clk(clk), .rst(rst), .wr_leg(wr_leg), .wr_ext(wr_ext), .cmd(wdata),
    .mask_q(mask_q), .mask_nxt(mask_nxt)
  );

  irqc_req_gate #(.NUM_SRC(NUM_SRC), .NUM_LEG(NUM_LEG)) u_gate (
    .clk(clk), .rst(rst), .flag_nxt(pend_nxt), .mask_nxt(mask_nxt),
    .req_leg(irq_legacy), .req_ext(irq_ext)
  );

  // read mux, registered
  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    unique case (ra)
      RA_FLAGS: begin
        rd_mux[NUM_SRC-1:0] = pend_q;
        rd_mux[NUM_SRC]     = button_held;
        rd_mux[NUM_SRC+1]   = card_removed;
      end
      RA_LMASK: rd_mux[NUM_LEG-1:0] = mask_q[NUM_LEG-1:0];
      RA_XMASK: rd_mux[NUM_SRC-1:0] = mask_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

  logic unused_ok;
  assign unused_ok = ^{NUM_EVT};
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int NUM_SRC = 14,
  parameter int NUM_LEG = 6
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_en,
  input logic [1:0]         addr,
  input logic [NUM_SRC-3:0] src_event,
  input logic               card_removed,
  input logic               irq_legacy,
  input logic               irq_ext,
  input logic [NUM_SRC-1:0] pend_q,
  input logic [NUM_SRC-1:0] mask_q
);
  localparam int NUM_EVT = NUM_SRC - 2;

  p_irq_leg_gate_r7: assert property (@(posedge clk) disable iff (rst)
    irq_legacy == |(pend_q[NUM_LEG-1:0] & mask_q[NUM_LEG-1:0]));

  p_irq_ext_gate_r7: assert property (@(posedge clk) disable iff (rst)
    irq_ext == |(pend_q[NUM_SRC-1:NUM_LEG] & mask_q[NUM_SRC-1:NUM_LEG]));

  p_event_latch_r2: assert property (@(posedge clk) disable iff (rst)
    (|src_event) |=> ((pend_q[NUM_EVT-1:0] & $past(src_event)) == $past(src_event)));

  p_mask_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && (addr == 2'd1 || addr == 2'd2)) |=> $stable(mask_q));

  p_card_flag_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(card_removed) |=> pend_q[NUM_SRC-1]);
endmodule

bind irq_mask_ctrl irqc_checker #(.NUM_SRC(NUM_SRC), .NUM_LEG(NUM_LEG)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .src_event(src_event),
  .card_removed(card_removed), .irq_legacy(irq_legacy), .irq_ext(irq_ext),
  .pend_q(pend_q), .mask_q(mask_q)
);

// File: tb/tb_irq_mask_ctrl.sv
`timescale 1ns/1ps
module tb_irq_mask_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [11:0] src_event = '0;
  logic [11:0] src_ack = '0;
  logic        card_removed = 1'b0;
  logic        button_held = 1'b0;
  logic        irq_legacy, irq_ext;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_mask_ctrl dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .src_event(src_event), .src_ack(src_ack), .card_removed(card_removed),
    .button_held(button_held), .irq_legacy(irq_legacy), .irq_ext(irq_ext)
  );

  // mask command table: address, command word, expected 14-bit mask afterwards
  localparam int NV = 8;
  localparam logic [1:0]  V_ADDR [NV] = '{2'd2, 2'd2, 2'd1, 2'd1, 2'd1, 2'd2, 2'd2, 2'd2};
  localparam logic [31:0] V_CMD  [NV] = '{32'h0AAA_AAAA, 32'h0000_0001, 32'h0000_0FFF,
                                         32'h0000_0555, 32'h0555_5002, 32'h0555_5000,
                                         32'h0000_0800, 32'h0800_0000};
  localparam logic [13:0] V_EXP  [NV] = '{14'h3FFF, 14'h3FFE, 14'h3FFE, 14'h3FC0,
                                         14'h3FC1, 14'h0001, 14'h0021, 14'h2021};

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; wr_en = 1'b0;
    @(posedge clk); #1;
    d = rdata;
  endtask

  task automatic pulse(input logic [11:0] ev, input logic [11:0] ak);
    @(negedge clk);
    src_event = ev; src_ack = ak;
    @(posedge clk); #1;
    src_event = '0; src_ack = '0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] rv;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;

    // R1: reset state
    check("R1 irq_legacy", {31'd0, irq_legacy}, 32'd0);
    check("R1 irq_ext", {31'd0, irq_ext}, 32'd0);
    bus_read(2'd0, rv); check("R1 flags", rv, 32'd0);
    bus_read(2'd2, rv); check("R1 ext mask", rv, 32'd0);

    // R4 R5 R6: table of mask commands through both views
    for (int i = 0; i < NV; i++) begin
      bus_write(V_ADDR[i], V_CMD[i]);
      bus_read(2'd2, rv); check("R4 R6 ext view", rv, {18'd0, V_EXP[i]});
      bus_read(2'd1, rv); check("R5 R6 legacy view", rv, {26'd0, V_EXP[i][5:0]});
    end

    // clear all mask bits
    bus_write(2'd2, 32'h0555_5555);
    bus_read(2'd2, rv); check("R4 clear all", rv, 32'd0);

    // R3: masked source still latches
    pulse(12'h004, 12'h000);
    check("R3 irq stays low", {31'd0, irq_legacy}, 32'd0);
    bus_read(2'd0, rv); check("R3 flag latched", rv, 32'h0000_0004);

    // R8: enabling mask on pending source raises line after write edge
    bus_write(2'd1, 32'h0000_0020);
    check("R8 irq_legacy", {31'd0, irq_legacy}, 32'd1);
    check("R7 irq_ext low", {31'd0, irq_ext}, 32'd0);

    // R2: acknowledge clears
    pulse(12'h000, 12'h004);
    check("R2 ack drops irq", {31'd0, irq_legacy}, 32'd0);
    bus_read(2'd0, rv); check("R2 flag cleared", rv, 32'd0);

    // R2: set wins over same-cycle ack
    pulse(12'h080, 12'h080);
    bus_read(2'd0, rv); check("R2 set wins", rv, 32'h0000_0080);
    check("R7 ext masked", {31'd0, irq_ext}, 32'd0);
    bus_write(2'd2, 32'h0000_8000);
    check("R7 irq_ext up", {31'd0, irq_ext}, 32'd1);
    check("R7 irq_legacy low", {31'd0, irq_legacy}, 32'd0);
    pulse(12'h000, 12'h080);
    check("R7 irq_ext down", {31'd0, irq_ext}, 32'd0);

    // R9 R10: card removal
    @(negedge clk); card_removed = 1'b1;
    @(posedge clk); #1;
    bus_read(2'd0, rv); check("R9 R10 card flag", rv, 32'h0000_A000);
    bus_write(2'd0, 32'h0000_2000);
    bus_read(2'd0, rv); check("R10 card clear", rv, 32'h0000_8000);

    // R9 R10: button press
    @(negedge clk); button_held = 1'b1;
    @(posedge clk); #1;
    bus_read(2'd0, rv); check("R9 R10 button flag", rv, 32'h0000_D000);
    bus_write(2'd0, 32'h0000_1000);
    bus_read(2'd0, rv); check("R10 button clear", rv, 32'h0000_C000);

    // R11: spare address
    bus_read(2'd3, rv); check("R11 spare reads zero", rv, 32'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule